// File: doc/BRIEF.md
# Dual-Core Package Deep-Sleep Sequencer

This block decides when a two-core package may drop into its deeper sleep level and then into a lower-voltage sub-level. It watches the C-state code and the performance-state code that each core requests. It tells the chipset about package entry and about each cache-shrink step by raising level-4 IO read request pulses. When the cache is empty and the feature is enabled, it sends one level-5 IO read request so that bus traffic is routed away from the cache. At most one request is in flight at a time, and each request is closed by an acknowledge input.

The active-low deep-sleep request goes low while the package sits in deeper sleep or in the reduced-voltage sub-level. The 7-bit voltage ID output follows the package level. It picks one of three codes, and these codes are captured from input pins while reset is held. Any core asking to leave C4 or to leave the lowest performance point sends the package straight back to normal operation. A shrink-prevention input keeps the cache at full size and blocks the reduced-voltage sub-level.

Top module: `dual_sleep_seq`

## Requirements
- R1: While reset is high and in the cycle after it, the package is in normal operation: `dslp_req_n` is 1, `vid` equals the captured normal code, and neither request pulse is high.
- R2: Package entry happens when both cores request C-state code 4 and performance code 0 while in normal operation with no request outstanding. One cycle later, `l4_read_req` pulses. The first `io_ack` after that moves the package to deeper sleep, so that in the next cycle `dslp_req_n` is 0 and `vid` equals the deeper code.
- R3: In deeper sleep with `cache_flushed` low, `shrink_block` low and nothing outstanding, a further `l4_read_req` pulse is raised as one shrink step. The next step is issued only after the previous one has been acknowledged.
- R4: In deeper sleep with `cache_flushed` high and `l5_enable` high, exactly one `l5_read_req` pulse is raised per sleep entry. After its acknowledge, the package moves to the reduced-voltage sub-level and `vid` equals the deep code.
- R5: In deeper sleep with `cache_flushed` high, `l5_enable` low and nothing outstanding, the package moves to the reduced-voltage sub-level in the next cycle without any level-5 pulse.
- R6: If either core requests a C-state code other than 4 or a performance code other than 0, any sleep level returns to normal on the next cycle: `dslp_req_n` goes to 1 and `vid` goes to the normal code.
- R7: While `shrink_block` is high in deeper sleep, no request pulses are raised and the reduced-voltage sub-level is never entered, whatever `cache_flushed` is. `vid` stays at the deeper code.
- R8: Each request pulse lasts one cycle. No new pulse is raised while a request is outstanding. An `io_ack` while nothing is outstanding has no effect.
- R9: The three voltage codes are captured only while reset is high. Later changes on the code inputs do not change `vid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core0_cstate | input | 3 | C-state code requested by core 0 (4 = C4) |
| core1_cstate | input | 3 | C-state code requested by core 1 (4 = C4) |
| core0_pstate | input | 4 | Performance code of core 0 (0 = lowest point) |
| core1_pstate | input | 4 | Performance code of core 1 (0 = lowest point) |
| cache_flushed | input | 1 | Cache fully shrunk to zero ways |
| shrink_block | input | 1 | Keep the cache at full size |
| l5_enable | input | 1 | Allow the level-5 IO read |
| io_ack | input | 1 | Acknowledge of the outstanding IO read |
| vid_normal_code | input | 7 | Voltage code for normal operation, captured in reset |
| vid_deeper_code | input | 7 | Voltage code for deeper sleep, captured in reset |
| vid_deep_code | input | 7 | Voltage code for the reduced-voltage sub-level, captured in reset |
| l4_read_req | output | 1 | One-cycle level-4 IO read request |
| l5_read_req | output | 1 | One-cycle level-5 IO read request |
| dslp_req_n | output | 1 | Deep-sleep request, active low |
| vid | output | 7 | Voltage ID code |

## Verification
A wrong package level shows up on `vid` and `dslp_req_n` in the very cycle the state register takes it, because both outputs are decoded straight from that register. A lost or stuck outstanding flag shows up within one acknowledge: either an expected shrink or entry pulse never appears, or an extra pulse appears while a request is still open. A broken exit decode leaves `dslp_req_n` low for one cycle too long after a core leaves C4. The directed scenarios sample at exactly these cycles.

// File: rtl/dss_pkg.sv
package dss_pkg;
   typedef enum logic [1:0] {
      ST_NORMAL  = 2'd0,
      ST_C4_PEND = 2'd1,
      ST_DEEPER  = 2'd2,
      ST_DEEPV   = 2'd3
   } dss_state_e;
endpackage

// File: rtl/dss_core_decode.sv
module dss_core_decode #(
   parameter int NCORE   = 2,
   parameter int CW      = 3,
   parameter int PW      = 4,
   parameter int C4_CODE = 4,
   parameter int PLOW    = 0
) (
   input  logic [NCORE*CW-1:0] cstate_i,
   input  logic [NCORE*PW-1:0] pstate_i,
   output logic                all_sleep_o
);
   logic [NCORE-1:0] core_ok;

   for (genvar i = 0; i < NCORE; i++) begin : g_core
      assign core_ok[i] = (cstate_i[i*CW +: CW] == CW'(C4_CODE)) &&
                          (pstate_i[i*PW +: PW] == PW'(PLOW));
   end

   assign all_sleep_o = &core_ok;
endmodule

// File: rtl/dss_ioreq.sv
module dss_ioreq (
   input  logic clk,
   input  logic rst,
   input  logic issue4_i,
   input  logic issue5_i,
   input  logic ack_i,
   output logic busy_o,
   output logic l4_o,
   output logic l5_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         busy_o <= 1'b0;
         l4_o   <= 1'b0;
         l5_o   <= 1'b0;
      end else begin
         l4_o <= issue4_i;
         l5_o <= issue5_i;
         if (issue4_i || issue5_i)
            busy_o <= 1'b1;
         else if (ack_i)
            busy_o <= 1'b0;
      end
   end
endmodule

// File: rtl/dss_vid_sel.sv
module dss_vid_sel
   import dss_pkg::*;
#(
   parameter int VW      = 7,
   parameter bit VID_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [VW-1:0] normal_i,
   input  logic [VW-1:0] deeper_i,
   input  logic [VW-1:0] deep_i,
   input  dss_state_e state_i,
   output logic [VW-1:0] vid_o
);
   logic [VW-1:0] code_normal_q, code_deeper_q, code_deep_q;
   logic [VW-1:0] vid_sel;

   always_ff @(posedge clk) begin
      if (rst) begin
         code_normal_q <= normal_i;
         code_deeper_q <= deeper_i;
         code_deep_q   <= deep_i;
      end
   end

   always_comb begin
      unique case (state_i)
         ST_DEEPER: vid_sel = code_deeper_q;
         ST_DEEPV:  vid_sel = code_deep_q;
         default:   vid_sel = code_normal_q;
      endcase
   end

   if (VID_REG) begin : g_vid_reg
      logic [VW-1:0] vid_q;
      always_ff @(posedge clk) begin
         if (rst) vid_q <= normal_i;
         else     vid_q <= vid_sel;
      end
      assign vid_o = vid_q;
   end else begin : g_vid_comb
      assign vid_o = vid_sel;
   end
endmodule

// File: rtl/dual_sleep_seq.sv
module dual_sleep_seq
   import dss_pkg::*;
#(
   parameter int CW      = 3,
   parameter int PW      = 4,
   parameter int VW      = 7,
   parameter int C4_CODE = 4,
   parameter int PLOW    = 0,
   parameter bit VID_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] core0_cstate,
   input  logic [CW-1:0] core1_cstate,
   input  logic [PW-1:0] core0_pstate,
   input  logic [PW-1:0] core1_pstate,
   input  logic          cache_flushed,
   input  logic          shrink_block,
   input  logic          l5_enable,
   input  logic          io_ack,
   input  logic [VW-1:0] vid_normal_code,
   input  logic [VW-1:0] vid_deeper_code,
   input  logic [VW-1:0] vid_deep_code,
   output logic          l4_read_req,
   output logic          l5_read_req,
   output logic          dslp_req_n,
   output logic [VW-1:0] vid
);
   localparam int NCORE = 2;

   initial begin
      if (CW < 1 || C4_CODE >= (1 << CW)) $error("C4_CODE does not fit CW");
      if (PW < 1 || PLOW >= (1 << PW))    $error("PLOW does not fit PW");
      if (VW < 1)                         $error("VW must be positive");
   end

   dss_state_e state_q, state_d;
   logic all_sleep, busy, issue4, issue5, l5_sent_q;

   dss_core_decode #(
      .NCORE(NCORE), .CW(CW), .PW(PW), .C4_CODE(C4_CODE), .PLOW(PLOW)
   ) u_decode (
      .cstate_i    ({core1_cstate, core0_cstate}),
      .pstate_i    ({core1_pstate, core0_pstate}),
      .all_sleep_o (all_sleep)
   );

   always_comb begin
      state_d = state_q;
      issue4  = 1'b0;
      issue5  = 1'b0;
      unique case (state_q)
         ST_NORMAL: begin
            if (all_sleep && !busy) begin
               state_d = ST_C4_PEND;
               issue4  = 1'b1;
            end
         end
         ST_C4_PEND: begin
            if (!all_sleep)          state_d = ST_NORMAL;
            else if (busy && io_ack) state_d = ST_DEEPER;
         end
         ST_DEEPER: begin
            if (!all_sleep) begin
               state_d = ST_NORMAL;
            end else if (!shrink_block && !busy) begin
               if (!cache_flushed)              issue4  = 1'b1;
               else if (l5_enable && !l5_sent_q) issue5 = 1'b1;
               else                              state_d = ST_DEEPV;
            end
         end
         ST_DEEPV: begin
            if (!all_sleep) state_d = ST_NORMAL;
         end
         default: state_d = ST_NORMAL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_NORMAL;
         l5_sent_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_NORMAL) l5_sent_q <= 1'b0;
         else if (issue5)          l5_sent_q <= 1'b1;
      end
   end

   dss_ioreq u_ioreq (
      .clk      (clk),
      .rst      (rst),
      .issue4_i (issue4),
      .issue5_i (issue5),
      .ack_i    (io_ack),
      .busy_o   (busy),
      .l4_o     (l4_read_req),
      .l5_o     (l5_read_req)
   );

   dss_vid_sel #(.VW(VW), .VID_REG(VID_REG)) u_vid (
      .clk      (clk),
      .rst      (rst),
      .normal_i (vid_normal_code),
      .deeper_i (vid_deeper_code),
      .deep_i   (vid_deep_code),
      .state_i  (state_q),
      .vid_o    (vid)
   );

   assign dslp_req_n = !((state_q == ST_DEEPER) || (state_q == ST_DEEPV));
endmodule

// File: rtl/dss_checker.sv
module dss_checker
   import dss_pkg::*;
#(
   parameter int CW      = 3,
   parameter int PW      = 4,
   parameter int C4_CODE = 4,
   parameter int PLOW    = 0
) (
   input logic          clk,
   input logic          rst,
   input logic [CW-1:0] c0,
   input logic [CW-1:0] c1,
   input logic [PW-1:0] p0,
   input logic [PW-1:0] p1,
   input logic          flushed,
   input logic          blk,
   input logic          l5en,
   input logic          ack,
   input logic          l4,
   input logic          l5,
   input logic          dslp_n,
   input dss_state_e    st
);
   logic all4, open_m;
   assign all4 = (c0 == CW'(C4_CODE)) && (c1 == CW'(C4_CODE)) &&
                 (p0 == PW'(PLOW)) && (p1 == PW'(PLOW));

   always_ff @(posedge clk) begin
      if (rst)                open_m <= 1'b0;
      else if (l4 || l5)      open_m <= !ack;
      else if (ack)           open_m <= 1'b0;
   end

   p_entry_req_r2: assert property (@(posedge clk) disable iff (rst)
      (st == ST_NORMAL && all4 && !open_m && !l4 && !l5) |=> l4);

   p_shrink_step_r3: assert property (@(posedge clk) disable iff (rst)
      (st == ST_DEEPER && all4 && !blk && !flushed && !open_m && !l4 && !l5) |=> l4);

   p_l5_gate_r4: assert property (@(posedge clk) disable iff (rst)
      l5 |-> $past(flushed && l5en && !blk));

   p_exit_r6: assert property (@(posedge clk) disable iff (rst)
      (!dslp_n && !all4) |=> dslp_n);

   p_block_r7: assert property (@(posedge clk) disable iff (rst)
      (st == ST_DEEPER && blk) |=> (st != ST_DEEPV && !l4 && !l5));

   p_pulse_width_r8: assert property (@(posedge clk) disable iff (rst)
      (l4 || l5) |=> !(l4 || l5));

   p_one_open_r8: assert property (@(posedge clk) disable iff (rst)
      open_m |-> !(l4 || l5));

   p_excl_r8: assert property (@(posedge clk) disable iff (rst)
      !(l4 && l5));
endmodule

bind dual_sleep_seq dss_checker #(
   .CW(CW), .PW(PW), .C4_CODE(C4_CODE), .PLOW(PLOW)
) u_dss_checker (
   .clk     (clk),
   .rst     (rst),
   .c0      (core0_cstate),
   .c1      (core1_cstate),
   .p0      (core0_pstate),
   .p1      (core1_pstate),
   .flushed (cache_flushed),
   .blk     (shrink_block),
   .l5en    (l5_enable),
   .ack     (io_ack),
   .l4      (l4_read_req),
   .l5      (l5_read_req),
   .dslp_n  (dslp_req_n),
   .st      (state_q)
);

// File: tb/dual_sleep_seq_bench.sv
module dual_sleep_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [6:0] V_NORM = 7'h50;
   localparam logic [6:0] V_DPR  = 7'h30;
   localparam logic [6:0] V_DEEP = 7'h18;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [2:0] c0 = '0, c1 = '0;
   logic [3:0] p0 = '0, p1 = '0;
   logic flushed = 1'b0, blk = 1'b0, l5en = 1'b0, ack = 1'b0;
   logic [6:0] vn = V_NORM, vd = V_DPR, vdp = V_DEEP;
   logic l4, l5, dslp_n;
   logic [6:0] vid;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_sleep_seq u_dual_sleep_seq (
      .clk(clk), .rst(rst),
      .core0_cstate(c0), .core1_cstate(c1),
      .core0_pstate(p0), .core1_pstate(p1),
      .cache_flushed(flushed), .shrink_block(blk),
      .l5_enable(l5en), .io_ack(ack),
      .vid_normal_code(vn), .vid_deeper_code(vd), .vid_deep_code(vdp),
      .l4_read_req(l4), .l5_read_req(l5),
      .dslp_req_n(dslp_n), .vid(vid)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(string req, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic expect_out(string req, int e_l4, int e_l5, int e_dn, int e_vid);
      check(req, "l4_read_req", int'(l4), e_l4);
      check(req, "l5_read_req", int'(l5), e_l5);
      check(req, "dslp_req_n", int'(dslp_n), e_dn);
      check(req, "vid", int'(vid), e_vid);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      c0 = 3'd0; c1 = 3'd0; p0 = 4'd0; p1 = 4'd0;
      flushed = 1'b0; blk = 1'b0; l5en = 1'b0; ack = 1'b0;
      vn = V_NORM; vd = V_DPR; vdp = V_DEEP;
      tick();
      tick();
      rst = 1'b0;
      vn = 7'h7F; vd = 7'h00; vdp = 7'h55;   // R9: ignored after reset
   endtask

   task automatic enter_c4();
      c0 = 3'd4; c1 = 3'd4; p0 = 4'd0; p1 = 4'd0;
   endtask

   // R1, R9: reset state and code capture
   task automatic t_reset();
      do_reset();
      expect_out("R1", 0, 0, 1, V_NORM);
      tick();
      expect_out("R9", 0, 0, 1, V_NORM);
   endtask

   // R2, R3, R5, R6, R9: entry, shrink steps, flush without level 5, exit
   task automatic t_shrink();
      do_reset();
      enter_c4();
      tick();
      expect_out("R2", 1, 0, 1, V_NORM);
      ack = 1'b1; tick(); ack = 1'b0;
      expect_out("R2", 0, 0, 0, V_DPR);
      tick();
      expect_out("R3", 1, 0, 0, V_DPR);
      tick();
      expect_out("R8", 0, 0, 0, V_DPR);
      ack = 1'b1; tick(); ack = 1'b0;
      expect_out("R3", 0, 0, 0, V_DPR);
      tick();
      expect_out("R3", 1, 0, 0, V_DPR);
      ack = 1'b1; flushed = 1'b1; tick(); ack = 1'b0;
      expect_out("R5", 0, 0, 0, V_DPR);
      tick();
      expect_out("R5", 0, 0, 0, V_DEEP);
      c1 = 3'd3; tick();
      expect_out("R6", 0, 0, 1, V_NORM);
   endtask

   // R4, R6: level-5 read after flush, exit by performance request
   task automatic t_level5();
      do_reset();
      flushed = 1'b1; l5en = 1'b1;
      enter_c4();
      tick();
      expect_out("R2", 1, 0, 1, V_NORM);
      ack = 1'b1; tick(); ack = 1'b0;
      expect_out("R2", 0, 0, 0, V_DPR);
      tick();
      expect_out("R4", 0, 1, 0, V_DPR);
      tick();
      expect_out("R4", 0, 0, 0, V_DPR);
      ack = 1'b1; tick(); ack = 1'b0;
      expect_out("R4", 0, 0, 0, V_DPR);
      tick();
      expect_out("R4", 0, 0, 0, V_DEEP);
      for (int i = 0; i < 4; i++) begin
         tick();
         expect_out("R4", 0, 0, 0, V_DEEP);
      end
      p0 = 4'd2; tick();
      expect_out("R6", 0, 0, 1, V_NORM);
   endtask

   // R7: shrink prevention
   task automatic t_block();
      do_reset();
      blk = 1'b1;
      enter_c4();
      tick();
      expect_out("R2", 1, 0, 1, V_NORM);
      ack = 1'b1; tick(); ack = 1'b0;
      for (int i = 0; i < 5; i++) begin
         tick();
         expect_out("R7", 0, 0, 0, V_DPR);
      end
      flushed = 1'b1; l5en = 1'b1;
      for (int i = 0; i < 4; i++) begin
         tick();
         expect_out("R7", 0, 0, 0, V_DPR);
      end
      c0 = 3'd1; tick();
      expect_out("R6", 0, 0, 1, V_NORM);
   endtask

   // R8: single outstanding request, stray acknowledge ignored
   task automatic t_outstanding();
      do_reset();
      ack = 1'b1; tick(); ack = 1'b0;
      expect_out("R8", 0, 0, 1, V_NORM);
      enter_c4();
      tick();
      expect_out("R2", 1, 0, 1, V_NORM);
      c0 = 3'd1; tick();
      expect_out("R6", 0, 0, 1, V_NORM);
      c0 = 3'd4; tick();
      expect_out("R8", 0, 0, 1, V_NORM);
      tick();
      expect_out("R8", 0, 0, 1, V_NORM);
      ack = 1'b1; tick(); ack = 1'b0;
      expect_out("R8", 0, 0, 1, V_NORM);
      tick();
      expect_out("R8", 1, 0, 1, V_NORM);
      ack = 1'b1; tick(); ack = 1'b0;
      flushed = 1'b1;
      tick();
      expect_out("R5", 0, 0, 0, V_DEEP);
      ack = 1'b1; tick(); tick(); ack = 1'b0;
      expect_out("R8", 0, 0, 0, V_DEEP);
      tick();
      expect_out("R8", 0, 0, 0, V_DEEP);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_shrink();
      t_level5();
      t_block();
      t_outstanding();
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end
endmodule